// File: doc/BRIEF.md
# Ramp-and-Bit Sequencer for a Bit-Serial Pixel Converter

This chip-level controller drives an array-wide converter in which every pixel owns only a comparator and a one-bit latch. For each output bit the controller sweeps a ramp code through a programmable threshold table. The code drives an external DAC. Next to the ramp it drives a single global bit line, `bitx`. A pixel latch follows `bitx` until the ramp rises above that pixel's input. From then on the latch keeps the value it held at the crossing. The controller shapes `bitx` so that, after a sweep for bit k, each latch holds bit k of that pixel's own code. One sweep is needed per bit, starting with the most significant bit. At the end of every sweep a one-cycle strobe tells the array readout that a bit plane can be read.

A conversion of n bits (1 to `MAX_BITS`) uses 2^n steps per sweep, which gives 2^n − 1 threshold crossings. Each step lasts a programmable number of clock cycles. The threshold table has 2^`MAX_BITS` entries and comes out of reset holding a linear ramp. It can be rewritten with any monotone curve, for example a gamma curve. A conversion with fewer bits than `MAX_BITS` uses every 2^(`MAX_BITS`−n)-th entry of the table.

The controller has four states:
- `ST_IDLE`: waiting for a start request.
- `ST_SETTLE`: the first cycle of a step. The new ramp code is on the output and `bitx` still holds its previous value.
- `ST_DWELL`: the rest of the step. `bitx` carries the bit for the current step.
- `ST_PLANE`: the one-cycle plane strobe.

The transitions are:
- IDLE→SETTLE on an accepted start.
- SETTLE→DWELL always.
- DWELL→SETTLE when a step ends and it is not the last step of the sweep.
- DWELL→PLANE when the last step of a sweep ends.
- PLANE→SETTLE when bits remain, which begins the next sweep at step 0.
- PLANE→IDLE after the plane for bit 0.

Top module: `rampseq_top`

## Requirements
- R1: During and after reset, `ramp_code`, `bitx`, `plane_valid`, `plane_index` and `busy` are all 0.
- R2: A start accepted in idle with an effective bit count n runs n sweeps of 2^n steps each. `busy` goes high in the cycle after the start and stays high through the plane strobe of the last sweep. That is n·(2^n·D + 1) cycles in total, where D is the effective dwell.
- R3: Every step lasts exactly D cycles. D equals the `dwell` input, except that values below 2 are taken as 2. During step j, `ramp_code` equals table entry j·2^(`MAX_BITS`−n).
- R4: In the sweep for bit k, `bitx` equals bit k of the step index j from the second cycle of step j onward. In the first cycle of each step, including step 0, `bitx` keeps its previous value. `bitx` never changes in a cycle in which `ramp_code` changes.
- R5: Sweeps run from bit n−1 down to bit 0. After the last step of each sweep, `plane_valid` is high for exactly one cycle while the ramp and `bitx` hold their final values. In that cycle `plane_index` equals the bit just converted, and it keeps that value until the next strobe.
- R6: A start request while `busy` is high is ignored. The running conversion continues unchanged.
- R7: The table resets to a linear ramp, with entry i = i·2^(`RAMP_W`−`MAX_BITS`). A write with `tbl_wr_en` high stores `tbl_wr_data` at `tbl_wr_addr` at the clock edge. With the linear table, a modelled pixel whose input is v ends with the code equal to the number of steps j ≥ 1 whose threshold is ≤ v.
- R8: With a rewritten non-linear monotone table, a modelled pixel ends with the count of thresholds (j ≥ 1) at or below its input. The bits are assembled from the planes by `plane_index`.
- R9: A `bit_count` of 0 is taken as 1, and a `bit_count` above `MAX_BITS` is taken as `MAX_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, taken only when idle |
| bit_count | input | BITS_W | Requested resolution n |
| dwell | input | DWELL_W | Cycles per ramp step (minimum 2) |
| tbl_wr_en | input | 1 | Threshold table write enable |
| tbl_wr_addr | input | MAX_BITS | Threshold table entry to write |
| tbl_wr_data | input | RAMP_W | Threshold value |
| ramp_code | output | RAMP_W | Code for the external ramp DAC |
| bitx | output | 1 | Global bit line that the pixel latches follow |
| plane_valid | output | 1 | One-cycle strobe: bit plane ready for readout |
| plane_index | output | IDX_W | Bit position of the plane just finished |
| busy | output | 1 | Conversion in progress |

## Verification
The case that is hardest to reach from the ports is a start request that arrives while `busy` is high, and above all one that arrives in the plane strobe cycle of the final sweep. At that point `busy` is still high but the very next state is idle. The bench raises start partway through a long conversion and checks that the total busy length and every per-cycle output still match the reference queue. The bench also places pixel inputs exactly on thresholds and at both ends of the range. This catches an off-by-one in the one-cycle `bitx` lag, because such an error would shift the latched bit for exactly those pixels.

// File: rtl/rampseq_pkg.sv
package rampseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DWELL  = 2'd2,
        ST_PLANE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rampseq_table.sv
module rampseq_table #(
    parameter int ADDR_W = 6,
    parameter int RAMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [RAMP_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RAMP_W-1:0] rd_data
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int LIN_SHFT = RAMP_W - ADDR_W;

    logic [RAMP_W-1:0] ent [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= RAMP_W'(i) << LIN_SHFT;
            end
        end else if (wr_en) begin
            ent[wr_addr] <= wr_data;
        end
    end

    assign rd_data = ent[rd_addr];

    AST_TBL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)))); // R7

endmodule

// File: rtl/rampseq_dwell_timer.sv
module rampseq_dwell_timer #(
    parameter int DWELL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [DWELL_W-1:0] len,
    output logic               done
);

    localparam logic [DWELL_W-1:0] CNT_MAX = {DWELL_W{1'b1}};

    logic [DWELL_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= DWELL_W'(1);
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == len);

    AST_DWELL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done); // R3

endmodule

// File: rtl/rampseq_ctrl.sv
module rampseq_ctrl
    import rampseq_pkg::*;
#(
    parameter int MAX_BITS = 6,
    parameter int RAMP_W   = 10,
    parameter int DWELL_W  = 8,
    parameter int BITS_W   = $clog2(MAX_BITS + 1),
    parameter int IDX_W    = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BITS_W-1:0]   bit_count,
    input  logic [DWELL_W-1:0]  dwell,
    output logic [MAX_BITS-1:0] tbl_rd_addr,
    input  logic [RAMP_W-1:0]   tbl_rd_data,
    input  logic                step_done,
    output logic                step_restart,
    output logic [DWELL_W-1:0]  dwell_len,
    output logic [RAMP_W-1:0]   ramp_code,
    output logic                bitx,
    output logic                plane_valid,
    output logic [IDX_W-1:0]    plane_index,
    output logic                busy
);

    localparam int                 STEP_W    = MAX_BITS;
    localparam logic [BITS_W-1:0]  MAXB      = BITS_W'(MAX_BITS);
    localparam logic [DWELL_W-1:0] MIN_DWELL = DWELL_W'(2);

    seq_state_e          state, state_nx;
    logic [STEP_W-1:0]   step, step_nx, last_step;
    logic [IDX_W-1:0]    k, k_nx;
    logic [BITS_W-1:0]   n_r, n_in, n_eff, sh_nx, sh_r;
    logic [DWELL_W-1:0]  d_r, d_in;
    logic                enter_step;
    logic                accept;

    // Requested resolution and dwell, clamped to their legal ranges
    assign n_in  = (bit_count == '0) ? BITS_W'(1) :
                   (bit_count > MAXB) ? MAXB : bit_count;
    assign d_in  = (dwell < MIN_DWELL) ? MIN_DWELL : dwell;
    assign accept = (state == ST_IDLE) && start;

    assign n_eff     = (state == ST_IDLE) ? n_in : n_r;
    assign sh_nx     = MAXB - n_eff;
    assign sh_r      = MAXB - n_r;
    assign last_step = {STEP_W{1'b1}} >> sh_r;

    assign tbl_rd_addr  = step_nx << sh_nx;
    assign step_restart = enter_step;
    assign dwell_len    = d_r;

    // Next-state decode
    always_comb begin
        state_nx   = state;
        step_nx    = step;
        k_nx       = k;
        enter_step = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx   = ST_SETTLE;
                    step_nx    = '0;
                    k_nx       = IDX_W'(n_in - 1'b1);
                    enter_step = 1'b1;
                end
            end
            ST_SETTLE: begin
                state_nx = ST_DWELL;
            end
            ST_DWELL: begin
                if (step_done) begin
                    if (step == last_step) begin
                        state_nx = ST_PLANE;
                    end else begin
                        state_nx   = ST_SETTLE;
                        step_nx    = step + 1'b1;
                        enter_step = 1'b1;
                    end
                end
            end
            ST_PLANE: begin
                if (k == '0) begin
                    state_nx = ST_IDLE;
                end else begin
                    state_nx   = ST_SETTLE;
                    step_nx    = '0;
                    k_nx       = k - 1'b1;
                    enter_step = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
            k     <= '0;
            n_r   <= BITS_W'(1);
            d_r   <= MIN_DWELL;
        end else begin
            state <= state_nx;
            step  <= step_nx;
            k     <= k_nx;
            if (accept) begin
                n_r <= n_in;
                d_r <= d_in;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_code   <= '0;
            bitx        <= 1'b0;
            plane_valid <= 1'b0;
            plane_index <= '0;
            busy        <= 1'b0;
        end else begin
            if (enter_step) begin
                ramp_code <= tbl_rd_data;
            end
            if (state == ST_SETTLE) begin
                bitx <= step[k];
            end
            plane_valid <= (state_nx == ST_PLANE);
            if (state_nx == ST_PLANE) begin
                plane_index <= k;
            end
            busy <= (state_nx != ST_IDLE);
        end
    end

    AST_PLANE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        plane_valid |=> !plane_valid); // R5
    AST_PLANE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        plane_valid |-> busy); // R2
    AST_BITX_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ramp_code) |-> $stable(bitx)); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !plane_valid && start) |=> busy); // R6
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step <= last_step)); // R3

endmodule

// File: rtl/rampseq_top.sv
module rampseq_top #(
    parameter int MAX_BITS = 6,
    parameter int RAMP_W   = 10,
    parameter int DWELL_W  = 8,
    parameter int BITS_W   = $clog2(MAX_BITS + 1),
    parameter int IDX_W    = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [BITS_W-1:0]   bit_count,
    input  logic [DWELL_W-1:0]  dwell,
    input  logic                tbl_wr_en,
    input  logic [MAX_BITS-1:0] tbl_wr_addr,
    input  logic [RAMP_W-1:0]   tbl_wr_data,
    output logic [RAMP_W-1:0]   ramp_code,
    output logic                bitx,
    output logic                plane_valid,
    output logic [IDX_W-1:0]    plane_index,
    output logic                busy
);

    logic [MAX_BITS-1:0] rd_addr;
    logic [RAMP_W-1:0]   rd_data;
    logic                step_done;
    logic                step_restart;
    logic [DWELL_W-1:0]  dwell_len;

    rampseq_table #(
        .ADDR_W (MAX_BITS),
        .RAMP_W (RAMP_W)
    ) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rampseq_dwell_timer #(
        .DWELL_W (DWELL_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (step_restart),
        .len     (dwell_len),
        .done    (step_done)
    );

    rampseq_ctrl #(
        .MAX_BITS (MAX_BITS),
        .RAMP_W   (RAMP_W),
        .DWELL_W  (DWELL_W),
        .BITS_W   (BITS_W),
        .IDX_W    (IDX_W)
    ) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .bit_count    (bit_count),
        .dwell        (dwell),
        .tbl_rd_addr  (rd_addr),
        .tbl_rd_data  (rd_data),
        .step_done    (step_done),
        .step_restart (step_restart),
        .dwell_len    (dwell_len),
        .ramp_code    (ramp_code),
        .bitx         (bitx),
        .plane_valid  (plane_valid),
        .plane_index  (plane_index),
        .busy         (busy)
    );

endmodule

// File: tb/test_rampseq_top.sv
`timescale 1ns/1ps
module test_rampseq_top;

    localparam int MAXB = 6;
    localparam int RW   = 10;
    localparam int DW   = 8;
    localparam int BW   = 3;
    localparam int IW   = 3;
    localparam int NPIX = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [BW-1:0] bit_count = '0;
    logic [DW-1:0] dwell = '0;
    logic          tbl_wr_en = 1'b0;
    logic [MAXB-1:0] tbl_wr_addr = '0;
    logic [RW-1:0] tbl_wr_data = '0;
    logic [RW-1:0] ramp_code;
    logic          bitx;
    logic          plane_valid;
    logic [IW-1:0] plane_index;
    logic          busy;

    rampseq_top i_rampseq_top (
        .clk (clk), .rst_n (rst_n), .start (start), .bit_count (bit_count),
        .dwell (dwell), .tbl_wr_en (tbl_wr_en), .tbl_wr_addr (tbl_wr_addr),
        .tbl_wr_data (tbl_wr_data), .ramp_code (ramp_code), .bitx (bitx),
        .plane_valid (plane_valid), .plane_index (plane_index), .busy (busy)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    int q_ramp[$];
    int q_bitx[$];
    int q_pv[$];
    int q_idx[$];
    int held_ramp = 0, held_bitx = 0, held_idx = 0;
    int tbl_m[64];
    int busy_cnt = 0;
    int conv_n = 1;
    int vin[NPIX];
    bit latch[NPIX];
    int code_acc[NPIX];
    bit gamma_on = 1'b0;

    function automatic int clamp_n(int b);
        if (b == 0) return 1;
        if (b > MAXB) return MAXB;
        return b;
    endfunction

    function automatic int clamp_d(int d);
        return (d < 2) ? 2 : d;
    endfunction

    function automatic int exp_code(int v);
        int c = 0;
        int sh = MAXB - conv_n;
        for (int j = 1; j < (1 << conv_n); j++) begin
            if (tbl_m[j << sh] <= v) c++;
        end
        return c;
    endfunction

    task automatic push_conv(int n, int d);
        int sh = MAXB - n;
        int b = held_bitx;
        int idx = held_idx;
        int r = 0;
        for (int k = n - 1; k >= 0; k--) begin
            for (int j = 0; j < (1 << n); j++) begin
                r = tbl_m[j << sh];
                for (int c = 0; c < d; c++) begin
                    if (c == 1) b = (j >> k) & 1;
                    q_ramp.push_back(r); q_bitx.push_back(b);
                    q_pv.push_back(0);   q_idx.push_back(idx);
                end
            end
            idx = k;
            q_ramp.push_back(r); q_bitx.push_back(b);
            q_pv.push_back(1);   q_idx.push_back(idx);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Reference comparison and pixel model, sampled at the falling edge
    always @(negedge clk) begin
        int er, eb, epv, ei, ebusy, ec;
        if (rst_n) begin
            cycles++;
            if (q_ramp.size() > 0) begin
                er = q_ramp.pop_front(); eb = q_bitx.pop_front();
                epv = q_pv.pop_front();  ei = q_idx.pop_front();
                ebusy = 1;
                held_ramp = er; held_bitx = eb; held_idx = ei;
            end else begin
                er = held_ramp; eb = held_bitx; epv = 0; ei = held_idx; ebusy = 0;
            end
            n_checks++;
            if (int'(ramp_code) != er || int'(bitx) != eb || int'(plane_valid) != epv ||
                int'(plane_index) != ei || int'(busy) != ebusy) begin
                n_fail++;
                $display("FAIL R3/R4/R5/R2 cycle %0d: ramp %0d/%0d bitx %0d/%0d pv %0d/%0d idx %0d/%0d busy %0d/%0d (actual/expected)",
                         cycles, ramp_code, er, bitx, eb, plane_valid, epv, plane_index, ei, busy, ebusy);
            end
            if (busy) busy_cnt++;
            // pixel comparators and latches
            for (int p = 0; p < NPIX; p++) begin
                if (int'(ramp_code) <= vin[p]) latch[p] = bitx;
                if (plane_valid) code_acc[p] |= int'(latch[p]) << plane_index;
            end
            if (plane_valid && plane_index == 0 && ebusy == 1 && epv == 1) begin
                for (int p = 0; p < NPIX; p++) begin
                    ec = exp_code(vin[p]);
                    n_checks++;
                    if (code_acc[p] != ec) begin
                        n_fail++;
                        if (gamma_on) $display("FAIL R8 pixel %0d: code %0d expected %0d", p, code_acc[p], ec);
                        else          $display("FAIL R7 pixel %0d: code %0d expected %0d", p, code_acc[p], ec);
                    end
                end
            end
            if (tbl_wr_en) tbl_m[tbl_wr_addr] = int'(tbl_wr_data);
            if (start && ebusy == 0) begin
                conv_n = clamp_n(int'(bit_count));
                push_conv(conv_n, clamp_d(int'(dwell)));
                busy_cnt = 0;
                for (int p = 0; p < NPIX; p++) code_acc[p] = 0;
            end
            if (cycles > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
                finish_run();
            end
        end
    end

    task automatic check_busy_len(string tag, int n, int d);
        int exp_len = n * ((1 << n) * d + 1);
        n_checks++;
        if (busy_cnt != exp_len) begin
            n_fail++;
            $display("FAIL %s busy length %0d expected %0d", tag, busy_cnt, exp_len);
        end
    endtask

    task automatic run_conv(int b, int d, int restart_after, string tag);
        @(posedge clk); #1;
        start = 1'b1; bit_count = BW'(b); dwell = DW'(d);
        @(posedge clk); #1;
        start = 1'b0;
        if (restart_after > 0) begin
            repeat (restart_after) @(posedge clk);
            #1; start = 1'b1; bit_count = BW'(1); dwell = DW'(9);
            @(posedge clk); #1; start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(posedge clk); #1;
        check_busy_len(tag, clamp_n(b), clamp_d(d));
    endtask

    task automatic write_tbl(int a, int v);
        @(posedge clk); #1;
        tbl_wr_en = 1'b1; tbl_wr_addr = MAXB'(a); tbl_wr_data = RW'(v);
        @(posedge clk); #1;
        tbl_wr_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) tbl_m[i] = i << (RW - MAXB);
        vin[0] = 0;   vin[1] = 5;    vin[2] = 128; vin[3] = 129;
        vin[4] = 500; vin[5] = 1023; vin[6] = 255; vin[7] = 800;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        n_checks++;
        if (ramp_code != '0 || bitx || plane_valid || plane_index != '0 || busy) begin
            n_fail++;
            $display("FAIL R1 reset outputs ramp %0d bitx %0d pv %0d idx %0d busy %0d expected all 0",
                     ramp_code, bitx, plane_valid, plane_index, busy);
        end
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R2 R3 R4 R5 R7: linear table, 3 bits, minimum dwell
        run_conv(3, 2, 0, "R2");
        // R6: start raised mid-conversion is ignored
        run_conv(4, 3, 40, "R6");
        // R9: bit count 0 taken as 1, dwell 0 taken as 2
        run_conv(0, 0, 0, "R9");
        // R9: bit count above the maximum clamps; full resolution
        run_conv(7, 2, 0, "R9");
        // R8: gamma-like table
        gamma_on = 1'b1;
        for (int i = 0; i < 64; i++) write_tbl(i, (i * i) >> 2);
        vin[2] = 4; vin[3] = 3; vin[6] = 992; vin[1] = 256;
        run_conv(6, 2, 0, "R8");
        run_conv(4, 3, 0, "R8");
        // R6: start in the final plane cycle region with one-bit conversion
        run_conv(1, 4, 8, "R6");
        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule